// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches a phase-locked loop's phase comparator from the digital side. On every comparison cycle it gets two single-cycle edge pulses, one from the divided reference and one from the divided feedback. It counts fast sampling-clock ticks between whichever edge arrives first and the edge that arrives second. Each measured error is sorted into one of three bands: small, intermediate or large.

An active-high lock flag rises once a selectable number of back-to-back cycles have small error. It falls at once on any single cycle with large error. An intermediate error restarts the run of small-error cycles but leaves an existing lock in place. The gap between the acquire bound and the loss bound therefore gives the flag hysteresis. If the second edge never arrives within a timeout window, that cycle counts as a large error.

The thresholds are given as tick counts equal to the intended time bounds, for example 15 and 25 ticks for 15 ns and 25 ns at a 1 GHz sampling clock. Both edge inputs must be pulses already synchronous to the sampling clock.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is low, and after it is released, the lock flag is 0 and the run of small-error cycles is empty, so a full run is needed before lock.
- R2: The error is the tick distance between the two edges. It is measured the same way whether the reference edge or the feedback edge comes first.
- R3: With `strict_sel` = 0, the lock flag rises after 3 consecutive small-error cycles and not after 2.
- R4: With `strict_sel` = 1, the lock flag rises after 5 consecutive small-error cycles and not after 4.
- R5: An error is small only when it is strictly less than `ACQ_TICKS`. An error equal to `ACQ_TICKS` is intermediate.
- R6: An error strictly greater than `LOSE_TICKS` clears the lock flag. An error equal to `LOSE_TICKS` is intermediate.
- R7: An intermediate error empties the run of small-error cycles and leaves the lock flag unchanged.
- R8: If the second edge has not come `TIMEOUT_TICKS` ticks after the first, the cycle is treated as a large error.
- R9: Both edges in the same tick give an error of 0, which is small.
- R10: The lock flag changes only on the second rising edge, counting the edge that samples the completing pulse. Between results it holds its value.
- R11: A repeat of the first-arriving edge while the other edge is still pending is ignored. The measurement stays anchored to the original first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, the tick of every error measurement |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-tick pulse marking the divided reference edge |
| fb_pulse | input | 1 | One-tick pulse marking the divided feedback edge |
| strict_sel | input | 1 | 0 needs 3 small-error cycles for lock, 1 needs 5 |
| lock_flag | output | 1 | Active-high lock indication |

## Verification
A measurement ends on the rising edge that samples the completing pulse. Its classified result is registered there, and the lock flag takes the result on the next rising edge, so the flag is due two edges after the sampling edge. A timeout result follows the same timing, counted from the edge where the tick count reaches `TIMEOUT_TICKS`. The bench drives every pulse on a falling edge and leaves four idle ticks after each completing pulse before sampling the flag on a falling edge. One directed test probes the falling edges right after the sampling edge and the one after that, to pin the exact cycle the flag changes.

// File: rtl/plm_pkg.sv
// Shared types for the lock monitor: result bands and timer states.
package plm_pkg;

    // Band a single comparison cycle falls into
    typedef enum logic [1:0] {
        CLS_GOOD = 2'd0,
        CLS_MID  = 2'd1,
        CLS_BAD  = 2'd2
    } err_class_t;

    // Which edge the phase timer is still waiting for
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_FB  = 2'd1,
        ST_WAIT_REF = 2'd2
    } timer_state_t;

    // Sort one measurement into a band; a timeout is always large
    function automatic err_class_t classify(input int unsigned err,
                                            input int unsigned acq,
                                            input int unsigned lose,
                                            input logic        timed_out);
        if (timed_out)    return CLS_BAD;
        if (err < acq)    return CLS_GOOD;
        if (err > lose)   return CLS_BAD;
        return CLS_MID;
    endfunction

endpackage

// File: rtl/plm_phase_timer.sv
// Phase timer: measures ticks from the first-arriving edge to the other.
// Assumes both pulses are one tick wide and synchronous to clk.
// Output is registered: meas_valid pulses on the tick after the edge
// that completes a measurement or the tick count reaches the timeout.
module plm_phase_timer #(
    parameter int unsigned TIMEOUT_TICKS = 200,
    localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_err,
    output logic             meas_timeout
);
    import plm_pkg::*;

    localparam logic [CNT_W-1:0] TMO_LIMIT = CNT_W'(TIMEOUT_TICKS);

    timer_state_t     state;
    logic [CNT_W-1:0] tick_cnt;
    logic             other_edge;

    // Pick the edge that would complete the pending measurement
    always_comb begin
        other_edge = (state == ST_WAIT_FB) ? fb_pulse : ref_pulse;
    end

    // Track the pending edge, count ticks and publish each result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            tick_cnt     <= '0;
            meas_valid   <= 1'b0;
            meas_err     <= '0;
            meas_timeout <= 1'b0;
        end else begin
            meas_valid   <= 1'b0;
            meas_timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_pulse && fb_pulse) begin
                        meas_valid <= 1'b1;
                        meas_err   <= '0;
                    end else if (ref_pulse) begin
                        state    <= ST_WAIT_FB;
                        tick_cnt <= CNT_W'(1);
                    end else if (fb_pulse) begin
                        state    <= ST_WAIT_REF;
                        tick_cnt <= CNT_W'(1);
                    end
                end
                ST_WAIT_FB, ST_WAIT_REF: begin
                    if (other_edge) begin
                        meas_valid <= 1'b1;
                        meas_err   <= tick_cnt;
                        state      <= ST_IDLE;
                    end else if (tick_cnt == TMO_LIMIT) begin
                        meas_valid   <= 1'b1;
                        meas_timeout <= 1'b1;
                        meas_err     <= tick_cnt;
                        state        <= ST_IDLE;
                    end else begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/plm_error_classifier.sv
// Error classifier: maps a measured tick count to a result band.
// Purely combinational; assumes ACQ_TICKS <= LOSE_TICKS < TIMEOUT_TICKS.
module plm_error_classifier #(
    parameter int unsigned ACQ_TICKS     = 15,
    parameter int unsigned LOSE_TICKS    = 25,
    parameter int unsigned TIMEOUT_TICKS = 200,
    localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic                meas_valid,
    input  logic [CNT_W-1:0]    meas_err,
    input  logic                meas_timeout,
    output logic                res_valid,
    output plm_pkg::err_class_t res_class
);
    import plm_pkg::*;

    // Band the measurement; the valid strobe passes straight through
    always_comb begin
        res_valid = meas_valid;
        res_class = classify(32'(meas_err), ACQ_TICKS, LOSE_TICKS, meas_timeout);
    end

endmodule

// File: rtl/plm_lock_tracker.sv
// Lock tracker: counts consecutive small-error results and owns the flag.
// Assumes STRICT_CNT >= LOOSE_CNT >= 1. Acts only on ticks with res_valid.
module plm_lock_tracker #(
    parameter int unsigned LOOSE_CNT  = 3,
    parameter int unsigned STRICT_CNT = 5,
    localparam int unsigned MAX_CNT = (STRICT_CNT > LOOSE_CNT) ? STRICT_CNT : LOOSE_CNT,
    localparam int unsigned GOOD_W  = $clog2(MAX_CNT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strict_sel,
    input  logic                res_valid,
    input  plm_pkg::err_class_t res_class,
    output logic                lock_flag,
    output logic [GOOD_W-1:0]   good_cnt
);
    import plm_pkg::*;

    logic [GOOD_W-1:0] need_cnt;
    logic [GOOD_W-1:0] next_cnt;

    // Run length required by the selected precision, and the next count
    always_comb begin
        need_cnt = strict_sel ? GOOD_W'(STRICT_CNT) : GOOD_W'(LOOSE_CNT);
        next_cnt = (good_cnt == GOOD_W'(MAX_CNT)) ? good_cnt : good_cnt + GOOD_W'(1);
    end

    // Update the run counter and lock flag once per result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt  <= '0;
            lock_flag <= 1'b0;
        end else if (res_valid) begin
            case (res_class)
                CLS_GOOD: begin
                    good_cnt <= next_cnt;
                    if (next_cnt >= need_cnt) lock_flag <= 1'b1;
                end
                CLS_MID: good_cnt <= '0;
                default: begin
                    good_cnt  <= '0;
                    lock_flag <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pll_lock_monitor.sv
// Digital PLL lock detector top: phase timer, classifier, lock tracker.
// Assumes ref_pulse and fb_pulse are one-tick pulses synchronous to clk.
module pll_lock_monitor #(
    parameter int unsigned ACQ_TICKS     = 15,
    parameter int unsigned LOSE_TICKS    = 25,
    parameter int unsigned TIMEOUT_TICKS = 200,
    parameter int unsigned LOOSE_CNT     = 3,
    parameter int unsigned STRICT_CNT    = 5,
    localparam int unsigned CNT_W   = $clog2(TIMEOUT_TICKS + 1),
    localparam int unsigned MAX_CNT = (STRICT_CNT > LOOSE_CNT) ? STRICT_CNT : LOOSE_CNT,
    localparam int unsigned GOOD_W  = $clog2(MAX_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic strict_sel,
    output logic lock_flag
);
    import plm_pkg::*;

    logic              meas_valid;
    logic [CNT_W-1:0]  meas_err;
    logic              meas_timeout;
    logic              res_valid;
    err_class_t        res_class;
    logic [GOOD_W-1:0] good_cnt;

    plm_phase_timer #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pulse   (ref_pulse),
        .fb_pulse    (fb_pulse),
        .meas_valid  (meas_valid),
        .meas_err    (meas_err),
        .meas_timeout(meas_timeout)
    );

    plm_error_classifier #(
        .ACQ_TICKS    (ACQ_TICKS),
        .LOSE_TICKS   (LOSE_TICKS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_class (
        .meas_valid  (meas_valid),
        .meas_err    (meas_err),
        .meas_timeout(meas_timeout),
        .res_valid   (res_valid),
        .res_class   (res_class)
    );

    plm_lock_tracker #(
        .LOOSE_CNT (LOOSE_CNT),
        .STRICT_CNT(STRICT_CNT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .strict_sel(strict_sel),
        .res_valid (res_valid),
        .res_class (res_class),
        .lock_flag (lock_flag),
        .good_cnt  (good_cnt)
    );

endmodule

// File: rtl/pll_lock_monitor_chk.sv
// Checker for pll_lock_monitor: relates lock flag changes to results.
module pll_lock_monitor_chk #(
    parameter int unsigned MAX_CNT = 5,
    parameter int unsigned GOOD_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lock_flag,
    input logic                res_valid,
    input plm_pkg::err_class_t res_class,
    input logic [GOOD_W-1:0]   good_cnt
);
    import plm_pkg::*;

    // R3: the flag only rises right after a small-error result
    assert_rise_after_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(res_valid && res_class == CLS_GOOD));

    // R6: a large-error result clears the flag on the next edge
    assert_bad_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_BAD) |=> !lock_flag);

    // R7: an intermediate result leaves the flag unchanged
    assert_mid_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_MID) |=> $stable(lock_flag));

    // R10: without a result the flag holds
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(lock_flag));

    // R4: the run counter never exceeds the longest required run
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt <= GOOD_W'(MAX_CNT));

    // R5: a published result always carries a defined band
    assert_class_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_class != 2'd3));

endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
    .MAX_CNT(MAX_CNT),
    .GOOD_W (GOOD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_flag(lock_flag),
    .res_valid(res_valid),
    .res_class(res_class),
    .good_cnt (good_cnt)
);

// File: tb/sim_pll_lock_monitor.sv
// Bench for pll_lock_monitor: vector table walk, then directed tests.
module sim_pll_lock_monitor;
    localparam int unsigned ACQ  = 15;
    localparam int unsigned LOSE = 25;
    localparam int unsigned TMO  = 40;
    localparam int NVEC = 20;

    // Vector: [11] feedback first, [10] strict_sel, [9] expected flag, [7:0] gap ticks
    localparam logic [11:0] VEC [NVEC] = '{
        12'h003, 12'h80E, 12'h200,            // R3 run of 3, R2 order, R9 zero gap
        12'h214, 12'hA05,                     // R7 intermediate keeps lock
        12'h01A,                              // R6 large error drops
        12'h00F, 12'h001, 12'h802, 12'h00F,   // R5 equal to bound restarts run
        12'h00E, 12'h80E, 12'h20E,            // R5 just below bound is small
        12'h219,                              // R6 equal to loss bound is intermediate
        12'h81E,                              // R6 above loss bound
        12'h402, 12'h402, 12'h402, 12'h402, 12'h602 // R4 run of 5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic strict_sel = 1'b0;
    logic lock_flag;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pll_lock_monitor #(
        .ACQ_TICKS(ACQ), .LOSE_TICKS(LOSE), .TIMEOUT_TICKS(TMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .strict_sel(strict_sel), .lock_flag(lock_flag)
    );

    function automatic string vec_tag(input int i);
        if (i == 1) return "R2";
        if (i < 3) return "R3";
        if (i < 5) return "R7";
        if (i == 5 || i == 13 || i == 14) return "R6";
        if (i < 15) return "R5";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lock_flag actual %b expected %b", tag, act, exp);
        end
    endtask

    // One comparison cycle: first edge, then the other after gap ticks, then 4 idle ticks
    task automatic do_cycle(input logic fb_first, input int gap);
        @(negedge clk);
        if (gap == 0) begin
            ref_pulse = 1'b1; fb_pulse = 1'b1;
        end else if (fb_first) fb_pulse = 1'b1;
        else ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0; fb_pulse = 1'b0;
        if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            if (fb_first) ref_pulse = 1'b1;
            else fb_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; fb_pulse = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", lock_flag, 1'b0);       // during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", lock_flag, 1'b0);       // after release

        for (int i = 0; i < NVEC; i++) begin
            strict_sel = VEC[i][10];
            do_cycle(VEC[i][11], int'(VEC[i][7:0]));
            check(vec_tag(i), lock_flag, VEC[i][9]);
        end

        // R1: reset clears the flag and the run
        do_reset();
        strict_sel = 1'b0;
        check("R1", lock_flag, 1'b0);
        do_cycle(1'b0, 2);
        do_cycle(1'b1, 2);
        check("R1", lock_flag, 1'b0);
        do_cycle(1'b0, 2);
        check("R3", lock_flag, 1'b1);

        // R8: missing second edge times out as a large error
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        repeat (TMO + 4) @(negedge clk);
        check("R8", lock_flag, 1'b0);

        // R10: flag changes on the second edge after the completing pulse is sampled
        do_cycle(1'b1, 3);
        do_cycle(1'b0, 3);
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        @(negedge clk);
        fb_pulse = 1'b1;
        @(negedge clk);
        fb_pulse = 1'b0;
        check("R10", lock_flag, 1'b0);
        @(negedge clk);
        check("R10", lock_flag, 1'b1);
        repeat (3) @(negedge clk);

        // R11: repeated first edge is ignored; gap measured from the original edge
        do_reset();
        do_cycle(1'b0, 2);
        do_cycle(1'b0, 2);
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        repeat (9) @(negedge clk);
        ref_pulse = 1'b1;                   // repeat at 10 ticks
        @(negedge clk);
        ref_pulse = 1'b0;
        repeat (9) @(negedge clk);
        fb_pulse = 1'b1;                    // other edge at 20 ticks: intermediate
        @(negedge clk);
        fb_pulse = 1'b0;
        repeat (4) @(negedge clk);
        do_cycle(1'b0, 2);
        check("R11", lock_flag, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule